// File: doc/BRIEF.md
# PoE Powered-Device Startup Sequencer

This block is the synchronous controller that brings a powered device up from a PoE link and then starts its isolated DC-DC converter. It reads only digital comparator flags and a one-millisecond tick. It drives the hotswap switch and its current-limit level, the startup current source for the bias rail, the soft-start discharge and charge controls, and the converter switching enable. Analog thresholds, current sources and the power stage sit outside the block.

Two state machines share the work. The hotswap machine has three states. `HS_OFF` moves to `HS_INRUSH` when the turn-on flag, the hold flag and the return-node flag are all high. `HS_INRUSH` moves to `HS_ON` once the operational current-limit level is latched and `INRUSH_MS` ticks have passed. Both `HS_INRUSH` and `HS_ON` fall back to `HS_OFF` when the hold flag drops.

The converter machine has seven states:
- `CV_OFF` moves to `CV_WAIT` once the hotswap leaves `HS_OFF`.
- `CV_WAIT` moves to `CV_DISCH` once the hotswap is in `HS_ON` and the bias rail is up. It returns to `CV_OFF` if the hotswap turns off.
- `CV_DISCH` moves to `CV_CHARGE` when the soft-start node is below its discharge level.
- `CV_CHARGE` moves to `CV_SOFT` at the offset threshold chosen by the mode input.
- `CV_SOFT` moves to `CV_RUN` at the handoff threshold.
- `CV_RUN` moves to `CV_REFRESH` on a light-load bias droop.
- `CV_REFRESH` returns to `CV_RUN` after `REFRESH_MS` ticks.
- From `CV_DISCH` through `CV_REFRESH`, a stop condition sends the machine to `CV_WAIT` (hiccup restart) if input power is still present, and to `CV_OFF` otherwise.

Top module: `pd_start_seq`

## Requirements
- R1: During and after synchronous reset `rst`, with no power flags asserted, every output is 0.
- R2: `hs_en` stays 0 unless `vin_on`, `vin_hold` and `rtn_high` are all 1. When they are, `hs_en` rises with `ilim_op`=0, which selects the inrush current-limit level.
- R3: During inrush, `start_en` is 1 and `sw_en` is 0.
- R4: Once `inrush_lim` reads 0 during inrush, `ilim_op` goes to 1, which selects the operational level. It stays 1 while the hotswap remains on.
- R5: Inrush ends only when `ilim_op` is 1 and at least `INRUSH_MS` (default 84) `ms_tick` pulses have occurred in inrush. Soft-start does not begin before inrush ends.
- R6: After inrush ends with `bias_on`=1, `ss_dis_en` is 1 until `ss_dis` reads 0. Then `ss_chg_en` is 1. The two controls are never 1 together.
- R7: `sw_en` rises when the offset flag chosen by `psr_mode` reads 1. With `psr_mode`=1 that flag is `ss_ofs_lo`; with `psr_mode`=0 it is `ss_ofs_hi`.
- R8: `start_en` drops to 0 once `ss_hand` reads 1, while `sw_en` stays 1.
- R9: When `bias_off_ok` reads 0, `sw_en` goes to 0 and `start_en` to 1. When the bias rail recovers with input power present, soft-start restarts with `ss_dis_en`=1.
- R10: When `bias_ll` reads 0 in steady run, `start_en` is 1 for `REFRESH_MS` (default 4) ticks. During this time `sw_en` and `ss_chg_en` stay 1 and no discharge occurs.
- R11: When `vin_hold` reads 0, `hs_en` goes to 0. The converter keeps switching unless `line_ok` is 0.
- R12: `sw_en` goes to 0 when `thermal_sd` is 1, when `ss_forced_low` is 1, or when the hotswap re-enters inrush with the current at its limit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| ms_tick | input | 1 | One-cycle pulse every millisecond |
| vin_on | input | 1 | Input voltage above turn-on threshold |
| vin_hold | input | 1 | Input voltage above turn-off threshold |
| rtn_high | input | 1 | Return node is high |
| inrush_lim | input | 1 | Inrush current near its limit |
| bias_on | input | 1 | Bias rail above turn-on threshold |
| bias_ll | input | 1 | Bias rail above light-load threshold |
| bias_off_ok | input | 1 | Bias rail above turn-off threshold |
| ss_dis | input | 1 | Soft-start node above discharge threshold |
| ss_ofs_lo | input | 1 | Soft-start node above low offset threshold |
| ss_ofs_hi | input | 1 | Soft-start node above high offset threshold |
| ss_hand | input | 1 | Soft-start node above handoff threshold |
| psr_mode | input | 1 | 1 = primary-side regulation, 0 = optocoupler peak-current mode |
| line_ok | input | 1 | Line undervoltage input, 0 = undervoltage |
| ss_forced_low | input | 1 | Soft-start pin pulled to ground |
| thermal_sd | input | 1 | Thermal shutdown active |
| hs_en | output | 1 | Hotswap switch enable |
| ilim_op | output | 1 | 1 = operational current limit, 0 = inrush limit |
| start_en | output | 1 | Startup current-source enable |
| ss_dis_en | output | 1 | Soft-start controlled discharge |
| ss_chg_en | output | 1 | Soft-start charge |
| sw_en | output | 1 | Converter switching enable |

## Verification
All outputs are decoded combinationally from state registers. A flag change driven before edge N therefore shows up at the outputs after edge N.

Some results need both machines to move, such as the start of discharge at the end of inrush, or a restart after the hotswap re-enters inrush. Those results appear after edge N+1, because the converter machine sees the hotswap state one edge late.

Inputs are driven at the falling edge. Each check waits at least two rising edges and samples at a falling edge. The tick-count boundaries are probed one tick short, where the old value must still hold, and then at the full count.

// File: rtl/pd_seq_pkg.sv
package pd_seq_pkg;
    typedef enum logic [1:0] {
        HS_OFF,
        HS_INRUSH,
        HS_ON
    } hs_state_e;

    typedef enum logic [2:0] {
        CV_OFF,
        CV_WAIT,
        CV_DISCH,
        CV_CHARGE,
        CV_SOFT,
        CV_RUN,
        CV_REFRESH
    } cv_state_e;
endpackage

// File: rtl/pd_tick_timer.sv
module pd_tick_timer #(
    parameter int LIMIT = 84
) (
    input  logic clk,
    input  logic rst,
    input  logic clr,
    input  logic tick,
    output logic done
);
    localparam int W = $clog2(LIMIT + 1);
    localparam logic [W-1:0] LIM = W'(LIMIT);

    logic [W-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            cnt <= '0;
        end else if (tick && cnt != LIM) begin
            cnt <= cnt + 1'b1;
        end
    end

    assign done = (cnt == LIM);
endmodule

// File: rtl/pd_hotswap_fsm.sv
module pd_hotswap_fsm
    import pd_seq_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      vin_on,
    input  logic      vin_hold,
    input  logic      rtn_high,
    input  logic      inrush_lim,
    input  logic      tmr_done,
    output hs_state_e state,
    output logic      limiting,
    output logic      hs_en,
    output logic      ilim_op
);
    hs_state_e nxt;
    logic      lim_op;
    logic      lim_op_nxt;

    always_ff @(posedge clk) begin
        if (rst) begin
            state  <= HS_OFF;
            lim_op <= 1'b0;
        end else begin
            state  <= nxt;
            lim_op <= lim_op_nxt;
        end
    end

    always_comb begin
        nxt = state;
        unique case (state)
            HS_OFF:    if (vin_on && vin_hold && rtn_high) nxt = HS_INRUSH;
            HS_INRUSH: begin
                if (!vin_hold)               nxt = HS_OFF;
                else if (lim_op && tmr_done) nxt = HS_ON;
            end
            HS_ON:     if (!vin_hold) nxt = HS_OFF;
            default:   nxt = HS_OFF;
        endcase
        lim_op_nxt = (state == HS_INRUSH && nxt == HS_INRUSH) ? (lim_op || !inrush_lim) : 1'b0;
    end

    always_comb begin
        hs_en    = (state != HS_OFF);
        ilim_op  = (state == HS_ON) || lim_op;
        limiting = (state == HS_INRUSH) && !lim_op;
    end
endmodule

// File: rtl/pd_conv_fsm.sv
module pd_conv_fsm
    import pd_seq_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  hs_state_e hs_state,
    input  logic      hs_limiting,
    input  logic      vin_hold,
    input  logic      bias_on,
    input  logic      bias_ll,
    input  logic      bias_off_ok,
    input  logic      ss_dis,
    input  logic      ss_ofs_lo,
    input  logic      ss_ofs_hi,
    input  logic      ss_hand,
    input  logic      psr_mode,
    input  logic      line_ok,
    input  logic      ss_forced_low,
    input  logic      thermal_sd,
    input  logic      refresh_done,
    output cv_state_e state,
    output logic      start_en,
    output logic      ss_dis_en,
    output logic      ss_chg_en,
    output logic      sw_en
);
    cv_state_e nxt;
    logic      stop;
    logic      rearm;
    logic      ofs_hit;

    always_ff @(posedge clk) begin
        if (rst) state <= CV_OFF;
        else     state <= nxt;
    end

    always_comb begin
        stop    = !bias_off_ok || hs_limiting || ss_forced_low || thermal_sd
                  || (hs_state == HS_OFF && !line_ok);
        rearm   = vin_hold && (hs_state != HS_OFF);
        ofs_hit = psr_mode ? ss_ofs_lo : ss_ofs_hi;
        nxt     = state;
        unique case (state)
            CV_OFF:  if (hs_state != HS_OFF) nxt = CV_WAIT;
            CV_WAIT: begin
                if (hs_state == HS_OFF)                             nxt = CV_OFF;
                else if (hs_state == HS_ON && bias_on && !stop)     nxt = CV_DISCH;
            end
            CV_DISCH, CV_CHARGE, CV_SOFT, CV_RUN, CV_REFRESH: begin
                if (stop) begin
                    nxt = rearm ? CV_WAIT : CV_OFF;
                end else begin
                    unique case (state)
                        CV_DISCH:   if (!ss_dis)      nxt = CV_CHARGE;
                        CV_CHARGE:  if (ofs_hit)      nxt = CV_SOFT;
                        CV_SOFT:    if (ss_hand)      nxt = CV_RUN;
                        CV_RUN:     if (!bias_ll)     nxt = CV_REFRESH;
                        CV_REFRESH: if (refresh_done) nxt = CV_RUN;
                        default:                      nxt = state;
                    endcase
                end
            end
            default: nxt = CV_OFF;
        endcase
    end

    always_comb begin
        start_en  = 1'b0;
        ss_dis_en = 1'b0;
        ss_chg_en = 1'b0;
        sw_en     = 1'b0;
        unique case (state)
            CV_OFF:     ;
            CV_WAIT:    start_en = 1'b1;
            CV_DISCH:   begin start_en = 1'b1; ss_dis_en = 1'b1; end
            CV_CHARGE:  begin start_en = 1'b1; ss_chg_en = 1'b1; end
            CV_SOFT:    begin start_en = 1'b1; ss_chg_en = 1'b1; sw_en = 1'b1; end
            CV_RUN:     begin ss_chg_en = 1'b1; sw_en = 1'b1; end
            CV_REFRESH: begin start_en = 1'b1; ss_chg_en = 1'b1; sw_en = 1'b1; end
            default:    ;
        endcase
    end
endmodule

// File: rtl/pd_start_seq.sv
module pd_start_seq
    import pd_seq_pkg::*;
#(
    parameter int INRUSH_MS  = 84,
    parameter int REFRESH_MS = 4
) (
    input  logic clk,
    input  logic rst,
    input  logic ms_tick,
    input  logic vin_on,
    input  logic vin_hold,
    input  logic rtn_high,
    input  logic inrush_lim,
    input  logic bias_on,
    input  logic bias_ll,
    input  logic bias_off_ok,
    input  logic ss_dis,
    input  logic ss_ofs_lo,
    input  logic ss_ofs_hi,
    input  logic ss_hand,
    input  logic psr_mode,
    input  logic line_ok,
    input  logic ss_forced_low,
    input  logic thermal_sd,
    output logic hs_en,
    output logic ilim_op,
    output logic start_en,
    output logic ss_dis_en,
    output logic ss_chg_en,
    output logic sw_en
);
    hs_state_e hs_state;
    cv_state_e cv_state;
    logic      hs_limiting;
    logic      inrush_done;
    logic      refresh_done;

    pd_tick_timer #(.LIMIT(INRUSH_MS)) u_inrush_tmr (
        .clk  (clk),
        .rst  (rst),
        .clr  (hs_state != HS_INRUSH),
        .tick (ms_tick),
        .done (inrush_done)
    );

    pd_tick_timer #(.LIMIT(REFRESH_MS)) u_refresh_tmr (
        .clk  (clk),
        .rst  (rst),
        .clr  (cv_state != CV_REFRESH),
        .tick (ms_tick),
        .done (refresh_done)
    );

    pd_hotswap_fsm u_hs (
        .clk        (clk),
        .rst        (rst),
        .vin_on     (vin_on),
        .vin_hold   (vin_hold),
        .rtn_high   (rtn_high),
        .inrush_lim (inrush_lim),
        .tmr_done   (inrush_done),
        .state      (hs_state),
        .limiting   (hs_limiting),
        .hs_en      (hs_en),
        .ilim_op    (ilim_op)
    );

    pd_conv_fsm u_cv (
        .clk           (clk),
        .rst           (rst),
        .hs_state      (hs_state),
        .hs_limiting   (hs_limiting),
        .vin_hold      (vin_hold),
        .bias_on       (bias_on),
        .bias_ll       (bias_ll),
        .bias_off_ok   (bias_off_ok),
        .ss_dis        (ss_dis),
        .ss_ofs_lo     (ss_ofs_lo),
        .ss_ofs_hi     (ss_ofs_hi),
        .ss_hand       (ss_hand),
        .psr_mode      (psr_mode),
        .line_ok       (line_ok),
        .ss_forced_low (ss_forced_low),
        .thermal_sd    (thermal_sd),
        .refresh_done  (refresh_done),
        .state         (cv_state),
        .start_en      (start_en),
        .ss_dis_en     (ss_dis_en),
        .ss_chg_en     (ss_chg_en),
        .sw_en         (sw_en)
    );
endmodule

// File: rtl/pd_seq_chk.sv
module pd_seq_chk (
    input logic clk,
    input logic rst,
    input logic vin_hold,
    input logic bias_off_ok,
    input logic thermal_sd,
    input logic ss_forced_low,
    input logic psr_mode,
    input logic ss_ofs_lo,
    input logic ss_ofs_hi,
    input logic hs_en,
    input logic ilim_op,
    input logic ss_dis_en,
    input logic ss_chg_en,
    input logic sw_en
);
    a_r2_inrush_level: assert property (@(posedge clk) disable iff (rst)
        $rose(hs_en) |-> !ilim_op);

    a_r6_dis_chg_excl: assert property (@(posedge clk) disable iff (rst)
        !(ss_dis_en && ss_chg_en));

    a_r7_offset_gate: assert property (@(posedge clk) disable iff (rst)
        $rose(sw_en) |-> $past(psr_mode ? ss_ofs_lo : ss_ofs_hi));

    a_r11_hotswap_drop: assert property (@(posedge clk) disable iff (rst)
        !vin_hold |=> !hs_en);

    a_r9_bias_stop: assert property (@(posedge clk) disable iff (rst)
        !bias_off_ok |=> !sw_en);

    a_r12_fault_stop: assert property (@(posedge clk) disable iff (rst)
        (thermal_sd || ss_forced_low) |=> !sw_en);

    a_r12_inrush_stop: assert property (@(posedge clk) disable iff (rst)
        (hs_en && !ilim_op) |=> !sw_en);
endmodule

bind pd_start_seq pd_seq_chk u_chk (
    .clk           (clk),
    .rst           (rst),
    .vin_hold      (vin_hold),
    .bias_off_ok   (bias_off_ok),
    .thermal_sd    (thermal_sd),
    .ss_forced_low (ss_forced_low),
    .psr_mode      (psr_mode),
    .ss_ofs_lo     (ss_ofs_lo),
    .ss_ofs_hi     (ss_ofs_hi),
    .hs_en         (hs_en),
    .ilim_op       (ilim_op),
    .ss_dis_en     (ss_dis_en),
    .ss_chg_en     (ss_chg_en),
    .sw_en         (sw_en)
);

// File: tb/test_pd_start_seq.sv
module test_pd_start_seq;
    logic clk = 1'b0;
    logic rst;
    logic ms_tick, vin_on, vin_hold, rtn_high, inrush_lim;
    logic bias_on, bias_ll, bias_off_ok;
    logic ss_dis, ss_ofs_lo, ss_ofs_hi, ss_hand, psr_mode;
    logic line_ok, ss_forced_low, thermal_sd;
    logic hs_en, ilim_op, start_en, ss_dis_en, ss_chg_en, sw_en;

    int total = 0;
    int bad   = 0;

    always #4 clk = ~clk;

    pd_start_seq i_pd_start_seq (
        .clk(clk), .rst(rst), .ms_tick(ms_tick), .vin_on(vin_on), .vin_hold(vin_hold),
        .rtn_high(rtn_high), .inrush_lim(inrush_lim), .bias_on(bias_on), .bias_ll(bias_ll),
        .bias_off_ok(bias_off_ok), .ss_dis(ss_dis), .ss_ofs_lo(ss_ofs_lo),
        .ss_ofs_hi(ss_ofs_hi), .ss_hand(ss_hand), .psr_mode(psr_mode), .line_ok(line_ok),
        .ss_forced_low(ss_forced_low), .thermal_sd(thermal_sd), .hs_en(hs_en),
        .ilim_op(ilim_op), .start_en(start_en), .ss_dis_en(ss_dis_en),
        .ss_chg_en(ss_chg_en), .sw_en(sw_en)
    );

    task automatic chk(input string req, input string what, input logic act, input logic exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s %s: actual=%b expected=%b", req, what, act, exp);
        end
    endtask

    task automatic step(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic tick(input int n);
        for (int i = 0; i < n; i++) begin
            ms_tick = 1'b1;
            @(negedge clk);
            ms_tick = 1'b0;
            @(negedge clk);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1;
        ms_tick = 0; vin_on = 0; vin_hold = 0; rtn_high = 0; inrush_lim = 1;
        bias_on = 0; bias_ll = 0; bias_off_ok = 0;
        ss_dis = 1; ss_ofs_lo = 0; ss_ofs_hi = 0; ss_hand = 0; psr_mode = 1;
        line_ok = 1; ss_forced_low = 0; thermal_sd = 0;
        step(3);
        rst = 1'b0;
        step(1);
    endtask

    // Brings the block to steady run with the given mode, checking nothing.
    task automatic bring_up(input logic mode);
        do_reset();
        psr_mode = mode;
        vin_on = 1; vin_hold = 1; rtn_high = 1;
        step(2);
        inrush_lim = 0;
        bias_on = 1; bias_ll = 1; bias_off_ok = 1;
        tick(84);
        step(3);
        ss_dis = 0;
        step(2);
        ss_ofs_lo = 1; ss_ofs_hi = 1;
        step(2);
        ss_hand = 1;
        step(2);
    endtask

    task automatic t_reset();
        do_reset();
        chk("R1", "hs_en", hs_en, 0);
        chk("R1", "ilim_op", ilim_op, 0);
        chk("R1", "start_en", start_en, 0);
        chk("R1", "ss_dis_en", ss_dis_en, 0);
        chk("R1", "ss_chg_en", ss_chg_en, 0);
        chk("R1", "sw_en", sw_en, 0);
    endtask

    task automatic t_hold_off();
        do_reset();
        vin_on = 1; vin_hold = 1; rtn_high = 0;
        step(3);
        chk("R2", "hs_en rtn low", hs_en, 0);
        vin_on = 0; rtn_high = 1;
        step(3);
        chk("R2", "hs_en below turn-on", hs_en, 0);
    endtask

    task automatic t_inrush();
        do_reset();
        vin_on = 1; vin_hold = 1; rtn_high = 1;
        step(2);
        chk("R2", "hs_en", hs_en, 1);
        chk("R2", "ilim_op inrush level", ilim_op, 0);
        chk("R3", "start_en in inrush", start_en, 1);
        chk("R3", "sw_en in inrush", sw_en, 0);
        bias_on = 1; bias_ll = 1; bias_off_ok = 1;
        tick(90);
        step(3);
        chk("R5", "no soft-start while at limit", ss_dis_en, 0);
        inrush_lim = 0;
        step(2);
        chk("R4", "ilim_op after current fall", ilim_op, 1);
        inrush_lim = 1;
        step(2);
        chk("R4", "ilim_op sticky", ilim_op, 1);
        do_reset();
        vin_on = 1; vin_hold = 1; rtn_high = 1;
        step(2);
        inrush_lim = 0;
        bias_on = 1; bias_ll = 1; bias_off_ok = 1;
        tick(83);
        step(3);
        chk("R5", "discharge before 84 ticks", ss_dis_en, 0);
        tick(1);
        step(2);
        chk("R5", "discharge at 84 ticks", ss_dis_en, 1);
        chk("R6", "no charge during discharge", ss_chg_en, 0);
        ss_dis = 0;
        step(2);
        chk("R6", "discharge ends", ss_dis_en, 0);
        chk("R6", "charge starts", ss_chg_en, 1);
    endtask

    task automatic t_softstart_psr();
        bring_up(1'b1);
        chk("R8", "start_en after handoff", start_en, 0);
        chk("R8", "sw_en after handoff", sw_en, 1);
        do_reset();
        vin_on = 1; vin_hold = 1; rtn_high = 1;
        step(2);
        inrush_lim = 0; bias_on = 1; bias_ll = 1; bias_off_ok = 1;
        tick(84);
        step(3);
        ss_dis = 0;
        step(2);
        ss_ofs_hi = 1;
        step(3);
        chk("R7", "psr ignores high flag", sw_en, 0);
        ss_ofs_lo = 1;
        step(2);
        chk("R7", "psr low offset enables", sw_en, 1);
        chk("R8", "start_en before handoff", start_en, 1);
    endtask

    task automatic t_softstart_opto();
        do_reset();
        psr_mode = 0;
        vin_on = 1; vin_hold = 1; rtn_high = 1;
        step(2);
        inrush_lim = 0; bias_on = 1; bias_ll = 1; bias_off_ok = 1;
        tick(84);
        step(3);
        ss_dis = 0;
        step(2);
        ss_ofs_lo = 1;
        step(3);
        chk("R7", "opto ignores low flag", sw_en, 0);
        ss_ofs_hi = 1;
        step(2);
        chk("R7", "opto high offset enables", sw_en, 1);
    endtask

    task automatic t_light_load();
        bring_up(1'b1);
        bias_ll = 0;
        step(2);
        chk("R10", "start_en on droop", start_en, 1);
        chk("R10", "sw_en held", sw_en, 1);
        chk("R10", "no discharge", ss_dis_en, 0);
        bias_ll = 1;
        tick(3);
        step(2);
        chk("R10", "start_en after 3 ticks", start_en, 1);
        chk("R10", "charge held", ss_chg_en, 1);
        tick(1);
        step(2);
        chk("R10", "start_en after 4 ticks", start_en, 0);
        chk("R10", "sw_en after refresh", sw_en, 1);
    endtask

    task automatic t_hiccup();
        bring_up(1'b1);
        bias_off_ok = 0; bias_ll = 0; bias_on = 0;
        step(2);
        chk("R9", "sw_en stopped", sw_en, 0);
        chk("R9", "start_en back on", start_en, 1);
        ss_dis = 1; ss_ofs_lo = 0; ss_ofs_hi = 0; ss_hand = 0;
        bias_on = 1; bias_ll = 1; bias_off_ok = 1;
        step(2);
        chk("R9", "restart with discharge", ss_dis_en, 1);
    endtask

    task automatic t_vin_drop();
        bring_up(1'b1);
        vin_on = 0; vin_hold = 0;
        step(2);
        chk("R11", "hs_en off", hs_en, 0);
        chk("R11", "sw_en kept", sw_en, 1);
        vin_on = 1; vin_hold = 1; inrush_lim = 1;
        step(3);
        chk("R12", "hs_en back in inrush", hs_en, 1);
        chk("R12", "ilim_op inrush", ilim_op, 0);
        chk("R12", "sw_en stop at inrush limit", sw_en, 0);
        bring_up(1'b1);
        vin_on = 0; vin_hold = 0; line_ok = 0;
        step(2);
        chk("R11", "line uv stops sw", sw_en, 0);
        chk("R11", "line uv no startup", start_en, 0);
    endtask

    task automatic t_faults();
        bring_up(1'b0);
        thermal_sd = 1;
        step(2);
        chk("R12", "thermal stop", sw_en, 0);
        bring_up(1'b1);
        ss_forced_low = 1;
        step(2);
        chk("R12", "ss forced low stop", sw_en, 0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        rst = 1'b1;
        t_reset();
        t_hold_off();
        t_inrush();
        t_softstart_psr();
        t_softstart_opto();
        t_light_load();
        t_hiccup();
        t_vin_drop();
        t_faults();
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule